// File: doc/BRIEF.md
# Processor Run/Halt Control Sequencer

This block decides when the clock of a 16-bit processor is allowed to advance. It takes operator pulses (start, stop, processor reset, peripheral reset) and level switches (single step, address stop, interrupt hold), together with strobes from the execution unit. From these it produces a run enable, a quiescent interrupt-wait status, and gated reset pulses.

A stop request never cuts an instruction short. Every stop condition is evaluated on the end-of-instruction strobe:

- the operator stop pulse, latched until that strobe;
- an executed halt instruction;
- single step;
- the current instruction address or the effective address equals the data switches while address stop is on.

After a processor reset, the next start either waits quietly for an interrupt or starts executing at once. Which one depends on the interrupt-hold switch.

Top module: `cpu_run_ctrl`

## Requirements
- R1: After reset, run_en, quiescent, cpu_rst_out and io_rst_out are all 0 and the block is halted.
- R2: While halted with no reset pending, a run_pb pulse sets run_en on the next cycle, with quiescent 0.
- R3: A halt_pb pulse while running is held until the next cycle with instr_end high. run_en stays 1 until that cycle and drops on the cycle after it.
- R4: In a cycle with run_en and instr_end both high, halt_instr high stops the block (run_en 0, quiescent 0 on the next cycle).
- R5: With step_sw high, every instr_end while running stops the block.
- R6: With adr_stop_sw high, instr_end while running stops the block if instr_addr or eff_addr equals data_sw. With adr_stop_sw low, a match has no effect.
- R7: A run_pb pulse while halted, with a processor reset pending (or cpu_rst_pb in the same cycle) and int_hold_sw low, enters the quiescent state: quiescent 1, run_en 0.
- R8: The same start with int_hold_sw high sets run_en directly.
- R9: The pending-reset flag is cleared by the start that acts on it. A later start without a new reset runs directly.
- R10: In the quiescent state, irq_req sets run_en on the next cycle and clears quiescent.
- R11: cpu_rst_pb and io_rst_pb while halted give a one-cycle pulse on cpu_rst_out or io_rst_out on the next cycle. While running or quiescent they give no pulse and set no pending reset.
- R12: lvl_hold equals int_hold_sw OR h_ff, combinationally.
- R13: halt_pb in the quiescent state returns the block to halted on the next cycle, even if irq_req is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_pb | input | 1 | Start pulse |
| halt_pb | input | 1 | Stop pulse |
| cpu_rst_pb | input | 1 | Processor reset pulse |
| io_rst_pb | input | 1 | Peripheral reset pulse |
| step_sw | input | 1 | Single-step level switch |
| adr_stop_sw | input | 1 | Address-stop level switch |
| int_hold_sw | input | 1 | Interrupt-hold level switch |
| h_ff | input | 1 | State of the program interrupt-inhibit flip-flop |
| halt_instr | input | 1 | Halt instruction executed (valid with instr_end) |
| instr_end | input | 1 | End-of-instruction strobe |
| irq_req | input | 1 | Program-level interrupt request |
| instr_addr | input | 16 | Address of the current instruction |
| eff_addr | input | 16 | Effective operand address |
| data_sw | input | 16 | Data switch value |
| run_en | output | 1 | Processor clock enable |
| quiescent | output | 1 | Waiting for an interrupt |
| cpu_rst_out | output | 1 | Reset pulse for level register, inhibit flip-flop and clock states |
| io_rst_out | output | 1 | Reset pulse for device controllers |
| lvl_hold | output | 1 | Blocks program-level changes; drives the inhibit lamp |

## Verification
The assertions assume that halt_instr is valid only together with instr_end. They also assume that each pulse input is sampled as an event for every cycle it is high, so a held pulse acts as several pulses.

The stimulus drives each pulse input high for one cycle at a time, keeps the level switches stable across each clock edge, and draws addresses and data switches from a four-value set so that address matches happen often. Overlapping pulses are allowed, and their priority is defined in R7 and R13.

// File: rtl/run_ctrl_pkg.sv
package run_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_QUIET = 2'd2
  } run_state_e;

  localparam int unsigned N_ADDR_SRC = 2;
endpackage

// File: rtl/rc_rst_sync.sv
module rc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rc_addr_cmp.sv
module rc_addr_cmp #(
  parameter int unsigned W = 16
) (
  input  logic         en,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] ref_val,
  output logic         hit
);
  assign hit = en && (addr == ref_val);
endmodule

// File: rtl/rc_stop_detect.sv
module rc_stop_detect #(
  parameter int unsigned W    = 16,
  parameter int unsigned NSRC = 2
) (
  input  logic                    step_sw,
  input  logic                    adr_stop_sw,
  input  logic                    halt_instr,
  input  logic                    stop_req,
  input  logic [NSRC-1:0][W-1:0]  addrs,
  input  logic [W-1:0]            data_sw,
  output logic                    stop_now
);
  logic [NSRC-1:0] hits;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    rc_addr_cmp #(.W(W)) u_cmp (
      .en      (adr_stop_sw),
      .addr    (addrs[g]),
      .ref_val (data_sw),
      .hit     (hits[g])
    );
  end

  always_comb begin
    stop_now = step_sw | halt_instr | stop_req | (|hits);
  end
endmodule

// File: rtl/rc_reset_gate.sv
module rc_reset_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic cpu_pb,
  input  logic io_pb,
  output logic cpu_rst_o,
  output logic io_rst_o
);
  logic cpu_d, io_d;
  logic cpu_q, io_q;

  always_comb begin
    cpu_d = allow & cpu_pb;
    io_d  = allow & io_pb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= 1'b0;
      io_q  <= 1'b0;
    end else begin
      cpu_q <= cpu_d;
      io_q  <= io_d;
    end
  end

  assign cpu_rst_o = cpu_q;
  assign io_rst_o  = io_q;

  assert_cpu_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_o |-> $past(allow && cpu_pb));
  assert_io_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    io_rst_o |-> $past(allow && io_pb));
endmodule

// File: rtl/cpu_run_ctrl.sv
module cpu_run_ctrl
  import run_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_pb,
  input  logic              halt_pb,
  input  logic              cpu_rst_pb,
  input  logic              io_rst_pb,
  input  logic              step_sw,
  input  logic              adr_stop_sw,
  input  logic              int_hold_sw,
  input  logic              h_ff,
  input  logic              halt_instr,
  input  logic              instr_end,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [ADDR_W-1:0] data_sw,
  output logic              run_en,
  output logic              quiescent,
  output logic              cpu_rst_out,
  output logic              io_rst_out,
  output logic              lvl_hold
);
  localparam int unsigned NSRC = N_ADDR_SRC;

  logic       rst_n_s;
  run_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       sreq_q, sreq_d;
  logic       stop_now;
  logic       halted;
  logic       pend_eff;
  logic [NSRC-1:0][ADDR_W-1:0] addr_vec;

  rc_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign addr_vec = {eff_addr, instr_addr};
  assign halted   = (state_q == ST_HALT);
  assign pend_eff = pend_q | cpu_rst_pb;

  rc_stop_detect #(.W(ADDR_W), .NSRC(NSRC)) u_stop (
    .step_sw     (step_sw),
    .adr_stop_sw (adr_stop_sw),
    .halt_instr  (halt_instr),
    .stop_req    (sreq_q | halt_pb),
    .addrs       (addr_vec),
    .data_sw     (data_sw),
    .stop_now    (stop_now)
  );

  rc_reset_gate u_rgate (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .allow     (halted),
    .cpu_pb    (cpu_rst_pb),
    .io_pb     (io_rst_pb),
    .cpu_rst_o (cpu_rst_out),
    .io_rst_o  (io_rst_out)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    sreq_d  = sreq_q;
    unique case (state_q)
      ST_HALT: begin
        if (cpu_rst_pb) pend_d = 1'b1;
        if (run_pb) begin
          state_d = (pend_eff && !int_hold_sw) ? ST_QUIET : ST_RUN;
          pend_d  = 1'b0;
        end
      end
      ST_RUN: begin
        sreq_d = sreq_q | halt_pb;
        if (instr_end && stop_now) state_d = ST_HALT;
      end
      ST_QUIET: begin
        if (halt_pb)      state_d = ST_HALT;
        else if (irq_req) state_d = ST_RUN;
      end
      default: state_d = ST_HALT;
    endcase
    if (state_d != ST_RUN) sreq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_HALT;
      pend_q  <= 1'b0;
      sreq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      sreq_q  <= sreq_d;
    end
  end

  assign run_en    = (state_q == ST_RUN);
  assign quiescent = (state_q == ST_QUIET);
  assign lvl_hold  = int_hold_sw | h_ff;

  assert_mid_instr_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_en && !instr_end) |=> run_en);
  assert_halt_instr_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_en && instr_end && halt_instr) |=> (!run_en && !quiescent));
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_en && instr_end && step_sw) |=> !run_en);
  assert_quiet_entry_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (halted && run_pb && pend_eff && !int_hold_sw) |=> (quiescent && !run_en));
  assert_irq_wake_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (quiescent && irq_req && !halt_pb) |=> run_en);
  assert_quiet_stop_R13: assert property (@(posedge clk) disable iff (!rst_n_s)
    (quiescent && halt_pb) |=> (!run_en && !quiescent));
endmodule

// File: tb/cpu_run_ctrl_test.sv
module cpu_run_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic run_pb, halt_pb, cpu_rst_pb, io_rst_pb;
  logic step_sw, adr_stop_sw, int_hold_sw, h_ff;
  logic halt_instr, instr_end, irq_req;
  logic [15:0] instr_addr, eff_addr, data_sw;
  logic run_en, quiescent, cpu_rst_out, io_rst_out, lvl_hold;

  int checks = 0;
  int errors = 0;
  int m_st;
  bit m_pend, m_hreq, done;

  always #10 clk = ~clk;

  cpu_run_ctrl uut (
    .clk(clk), .rst_n(rst_n), .run_pb(run_pb), .halt_pb(halt_pb),
    .cpu_rst_pb(cpu_rst_pb), .io_rst_pb(io_rst_pb), .step_sw(step_sw),
    .adr_stop_sw(adr_stop_sw), .int_hold_sw(int_hold_sw), .h_ff(h_ff),
    .halt_instr(halt_instr), .instr_end(instr_end), .irq_req(irq_req),
    .instr_addr(instr_addr), .eff_addr(eff_addr), .data_sw(data_sw),
    .run_en(run_en), .quiescent(quiescent), .cpu_rst_out(cpu_rst_out),
    .io_rst_out(io_rst_out), .lvl_hold(lvl_hold)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit adr_hit();
    return adr_stop_sw && (instr_addr == data_sw || eff_addr == data_sw);
  endfunction

  // One clock: compute expected state from requirements, advance, compare.
  task automatic cyc(input string tag);
    int nst = m_st;
    bit np = m_pend, nh = m_hreq, nc = 0, ni = 0;
    case (m_st)
      0: begin
        if (cpu_rst_pb) begin np = 1; nc = 1; end
        if (io_rst_pb) ni = 1;
        if (run_pb) begin
          nst = ((m_pend || cpu_rst_pb) && !int_hold_sw) ? 2 : 1;
          np = 0;
        end
      end
      1: begin
        nh = m_hreq | halt_pb;
        if (instr_end && (halt_instr || step_sw || nh || adr_hit())) nst = 0;
      end
      default: begin
        if (halt_pb) nst = 0;
        else if (irq_req) nst = 1;
      end
    endcase
    if (nst != 1) nh = 0;
    m_st = nst; m_pend = np; m_hreq = nh;
    @(negedge clk);
    chk(tag, "run_en", run_en, nst == 1);
    chk(tag, "quiescent", quiescent, nst == 2);
    chk(tag, "cpu_rst_out", cpu_rst_out, nc);
    chk(tag, "io_rst_out", io_rst_out, ni);
    chk(tag, "lvl_hold", lvl_hold, int_hold_sw | h_ff);
    run_pb = 0; halt_pb = 0; cpu_rst_pb = 0; io_rst_pb = 0;
    instr_end = 0; halt_instr = 0; irq_req = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0;
    {run_pb, halt_pb, cpu_rst_pb, io_rst_pb, step_sw, adr_stop_sw} = '0;
    {int_hold_sw, h_ff, halt_instr, instr_end, irq_req} = '0;
    instr_addr = 0; eff_addr = 0; data_sw = 16'hFFFF;
    m_st = 0; m_pend = 0; m_hreq = 0; done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    cyc("R1");
    // R2 plain start
    run_pb = 1; cyc("R2");
    // R3 stop waits for end of instruction
    halt_pb = 1; cyc("R3");
    cyc("R3"); cyc("R3");
    instr_end = 1; cyc("R3"); cyc("R3");
    // R4 halt instruction
    run_pb = 1; cyc("R4");
    instr_end = 1; cyc("R4");
    instr_end = 1; halt_instr = 1; cyc("R4");
    // R5 single step
    step_sw = 1;
    run_pb = 1; cyc("R5"); instr_end = 1; cyc("R5");
    run_pb = 1; cyc("R5"); cyc("R5"); instr_end = 1; cyc("R5");
    step_sw = 0;
    // R6 address stop on both sources
    data_sw = 16'h1234; adr_stop_sw = 1;
    run_pb = 1; cyc("R6");
    instr_addr = 16'h1234; instr_end = 1; cyc("R6");
    instr_addr = 0; run_pb = 1; cyc("R6");
    eff_addr = 16'h1234; instr_end = 1; cyc("R6");
    adr_stop_sw = 0; run_pb = 1; cyc("R6");
    instr_end = 1; cyc("R6");
    halt_pb = 1; instr_end = 1; cyc("R6");
    eff_addr = 0;
    // R11 reset pulses while halted, R7 quiescent entry
    cpu_rst_pb = 1; cyc("R11"); io_rst_pb = 1; cyc("R11");
    run_pb = 1; cyc("R7");
    cpu_rst_pb = 1; io_rst_pb = 1; cyc("R11");
    // R10 interrupt wake
    irq_req = 1; cyc("R10");
    cpu_rst_pb = 1; io_rst_pb = 1; cyc("R11");
    halt_pb = 1; instr_end = 1; cyc("R11");
    // R9 pending cleared; ignored reset must not arm it
    run_pb = 1; cyc("R9");
    halt_pb = 1; instr_end = 1; cyc("R9");
    // R8 reset then start with hold on
    int_hold_sw = 1; cpu_rst_pb = 1; cyc("R8");
    run_pb = 1; cyc("R8");
    halt_pb = 1; instr_end = 1; cyc("R8");
    int_hold_sw = 0;
    // R13 stop beats interrupt in quiescent state
    cpu_rst_pb = 1; run_pb = 1; cyc("R13");
    halt_pb = 1; irq_req = 1; cyc("R13");
    // R12 lamp combinations
    h_ff = 1; cyc("R12"); int_hold_sw = 1; cyc("R12");
    h_ff = 0; cyc("R12"); int_hold_sw = 0; cyc("R12");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      run_pb      = ($urandom % 6) == 0;
      halt_pb     = ($urandom % 12) == 0;
      cpu_rst_pb  = ($urandom % 14) == 0;
      io_rst_pb   = ($urandom % 14) == 0;
      irq_req     = ($urandom % 5) == 0;
      instr_end   = ($urandom % 3) == 0;
      halt_instr  = instr_end && (($urandom % 10) == 0);
      if (($urandom % 20) == 0) step_sw = ~step_sw;
      if (($urandom % 15) == 0) adr_stop_sw = ~adr_stop_sw;
      if (($urandom % 15) == 0) int_hold_sw = ~int_hold_sw;
      h_ff        = $urandom % 2;
      instr_addr  = 16'($urandom % 4);
      eff_addr    = 16'($urandom % 4);
      data_sw     = 16'($urandom % 4);
      cyc("RND");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule